// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block distributes a bank of shared interrupt lines to several processor cores. Its main use is inter-processor signalling. Each shared line keeps its own set of target cores, a destination mode and a trigger mode. Each core receives one private output per shared line. With the default sizes the bank holds 16 lines, and a core that numbers its private inputs from 16 upward sees shared line n on input 16+n.

Software controls the block through one small register port. A staging word is loaded first. A command then names a line index and an operation. Configuration commands take their operand from the staging word. Status commands overwrite the staging word with a per-core bitmask, which software then reads back. Each line tracks two status bits per core. The pending bit stays set until the core reports that it has taken the event. The acknowledged bit is set only when software explicitly clears the line. A global enable gates every output and must be dropped while the block is being reconfigured.

Top module: `irq_distributor`

## Requirements
- R1: After reset all interrupt outputs are low, `reg_rdata` reads 0, the block is disabled, and every line has mask 0, level trigger and deliver-to-all mode.
- R2: A write with `reg_addr`=0 loads the staging word. A write with `reg_addr`=2 sets the global enable from bit 0. A write with `reg_addr`=1 is a command: bits [7:0] carry the code (1 write-mode, 2 write-mask, 3 raise, 4 clear, 5 read-ack, 6 read-pending) and bits [15:8] carry the line index. `reg_rdata` always shows the staging word.
- R3: Write-mask copies staging bits [NUM_CORES-1:0] into the line's target mask. With a one-core mask, a raise drives only that core's output for that line. Output bit c*NUM_IRQS+n belongs to core c, line n.
- R4: With a multi-core mask, a raise drives the outputs of every selected core.
- R5: Write-mode takes the destination mode from staging bits [2:0] and the trigger from bit 8 (1 = pulse, 0 = level). Destination 1 delivers only to the lowest-numbered core in the mask. Every other value delivers to all cores in the mask.
- R6: In level trigger, a delivered output rises in the cycle after the raise command. It stays high, even after a take, until a clear command for that line.
- R7: In pulse trigger, a delivered output is high for exactly the one cycle after the raise command.
- R8: A raise sets the pending bit of each delivered core. Take input bit c*NUM_IRQS+n clears only core c's pending bit for line n. Read-pending loads the line's pending mask into staging bits [NUM_CORES-1:0] and zeroes the upper bits.
- R9: A clear sets the acknowledged bit only for cores that hold an active delivery. A take alone never sets it, and a new raise resets it for the delivered cores. Read-ack returns the acknowledged mask the same way read-pending returns the pending mask.
- R10: While disabled, raise commands have no effect and all outputs are low. Line state is kept, so an active level output returns when the block is enabled again.
- R11: When a raise command and a take for the same core and line arrive in the same cycle, the pending bit ends set.
- R12: A command whose index is NUM_IRQS or above, or whose code is not 1 to 6, changes neither the outputs, the line state nor the staging word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 staging word, 1 command, 2 enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Staging word |
| take_i | input | NUM_CORES*NUM_IRQS | Per core, per line: the core has taken the interrupt |
| irq_o | output | NUM_CORES*NUM_IRQS | Per core, per line interrupt outputs |

## Verification
A raise command and a core's take can land on the same line in one clock edge. Both update the same pending bit, so the block must choose one. The bench provokes this by driving a take bit together with the raise command write. It then reads the pending mask back and expects the bit to be set, and it expects the level output to be up. A second collision also comes up: a take that arrives while the output is still held. The bench checks that this take neither drops the level output nor sets the acknowledged bit.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam logic [1:0] ADDR_PARAM = 2'd0;
    localparam logic [1:0] ADDR_CMD   = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    typedef enum logic [7:0] {
        CMD_NONE    = 8'd0,
        CMD_WMODE   = 8'd1,
        CMD_WMASK   = 8'd2,
        CMD_RAISE   = 8'd3,
        CMD_CLEAR   = 8'd4,
        CMD_RD_ACK  = 8'd5,
        CMD_RD_PEND = 8'd6
    } cmd_e;

    localparam logic [2:0] DEST_ALL    = 3'd0;
    localparam logic [2:0] DEST_LOWEST = 3'd1;
    localparam int         MODE_PULSE_BIT = 8;

    typedef struct packed {
        logic       pulse;
        logic [2:0] dest;
    } irq_mode_t;

    typedef struct packed {
        logic       valid;
        cmd_e       code;
        logic [7:0] idx;
    } cmd_t;

    function automatic irq_mode_t mode_from_word(input logic [15:0] w);
        irq_mode_t m;
        m.pulse = w[MODE_PULSE_BIT];
        m.dest  = w[2:0];
        return m;
    endfunction

    function automatic logic [31:0] isolate_lowest(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

    function automatic logic code_known(input logic [7:0] c);
        return (c >= 8'd1) && (c <= 8'd6);
    endfunction

endpackage

// File: rtl/irqd_cmd_decode.sv
module irqd_cmd_decode
    import irqd_pkg::*;
#(
    parameter int NUM_IRQS = 16
) (
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [15:0]         cmd_word,
    output logic                param_we,
    output logic                ctrl_we,
    output cmd_t                cmd,
    output logic [NUM_IRQS-1:0] line_sel,
    output logic                rd_req,
    output logic                rd_is_ack
);

    logic in_range;
    logic cmd_ok;

    always_comb begin
        in_range  = 32'(cmd_word[15:8]) < NUM_IRQS;
        cmd_ok    = reg_wr && (reg_addr == ADDR_CMD) && in_range && code_known(cmd_word[7:0]);
        param_we  = reg_wr && (reg_addr == ADDR_PARAM);
        ctrl_we   = reg_wr && (reg_addr == ADDR_CTRL);
        cmd.valid = cmd_ok;
        cmd.code  = cmd_ok ? cmd_e'(cmd_word[7:0]) : CMD_NONE;
        cmd.idx   = cmd_word[15:8];
        rd_req    = cmd_ok && ((cmd.code == CMD_RD_ACK) || (cmd.code == CMD_RD_PEND));
        rd_is_ack = cmd.code == CMD_RD_ACK;
    end

    for (genvar n = 0; n < NUM_IRQS; n++) begin : g_sel
        assign line_sel[n] = cmd_ok && (cmd_word[15:8] == 8'(n));
    end

endmodule

// File: rtl/irqd_line.sv
module irqd_line
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  cmd_e                 code,
    input  irq_mode_t            mode_in,
    input  logic [NUM_CORES-1:0] mask_in,
    input  logic                 en,
    input  logic [NUM_CORES-1:0] take,
    output logic [NUM_CORES-1:0] irq,
    output logic [NUM_CORES-1:0] pend,
    output logic [NUM_CORES-1:0] ack,
    output logic                 pulse_mode
);

    irq_mode_t            mode_q;
    logic [NUM_CORES-1:0] mask_q;
    logic [NUM_CORES-1:0] active_q, pend_q, ack_q, pulse_q;
    logic [NUM_CORES-1:0] deliver;
    logic [NUM_CORES-1:0] active_d, pend_d, ack_d;
    logic [31:0]          low_bit;
    logic                 do_raise, do_clear;

    always_comb begin
        low_bit  = isolate_lowest(32'(mask_q));
        deliver  = (mode_q.dest == DEST_LOWEST) ? low_bit[NUM_CORES-1:0] : mask_q;
        do_raise = sel && (code == CMD_RAISE) && en;
        do_clear = sel && (code == CMD_CLEAR);

        active_d = active_q;
        pend_d   = pend_q & ~take;
        ack_d    = ack_q;
        if (do_raise) begin
            active_d = active_q | deliver;
            pend_d   = pend_d | deliver;
            ack_d    = ack_q & ~deliver;
        end else if (do_clear) begin
            active_d = active_q & ~deliver;
            pend_d   = pend_d & ~deliver;
            ack_d    = ack_q | (active_q & deliver);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '{pulse: 1'b0, dest: DEST_ALL};
            mask_q   <= '0;
            active_q <= '0;
            pend_q   <= '0;
            ack_q    <= '0;
            pulse_q  <= '0;
        end else begin
            if (sel && code == CMD_WMODE) mode_q <= mode_in;
            if (sel && code == CMD_WMASK) mask_q <= mask_in;
            active_q <= active_d;
            pend_q   <= pend_d;
            ack_q    <= ack_d;
            pulse_q  <= (do_raise && mode_q.pulse) ? deliver : '0;
        end
    end

    assign irq        = en ? (mode_q.pulse ? pulse_q : active_q) : '0;
    assign pend       = pend_q;
    assign ack        = ack_q;
    assign pulse_mode = mode_q.pulse;

endmodule

// File: rtl/irqd_status_sel.sv
module irqd_status_sel #(
    parameter int NUM_CORES = 4,
    parameter int NUM_IRQS  = 16,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1
) (
    input  logic [NUM_IRQS-1:0][NUM_CORES-1:0] pend_all,
    input  logic [NUM_IRQS-1:0][NUM_CORES-1:0] ack_all,
    input  logic [LINE_W-1:0]                  idx,
    input  logic                               want_ack,
    output logic [DATA_W-1:0]                  word
);

    logic [NUM_CORES-1:0] picked;

    always_comb begin
        picked = want_ack ? ack_all[idx] : pend_all[idx];
        word   = DATA_W'(picked);
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_IRQS  = 16,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [1:0]                    reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [NUM_CORES*NUM_IRQS-1:0] take_i,
    output logic [NUM_CORES*NUM_IRQS-1:0] irq_o
);

    localparam int LINE_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1;

    logic                               param_we, ctrl_we, rd_req, rd_is_ack;
    cmd_t                               cmd;
    logic [NUM_IRQS-1:0]                line_sel;
    logic [DATA_W-1:0]                  param_q, status_word;
    logic                               en_q;
    irq_mode_t                          mode_word;
    logic [NUM_IRQS-1:0][NUM_CORES-1:0] line_irq, line_take, line_pend, line_ack;
    logic [NUM_IRQS-1:0]                pulse_lines;

    irqd_cmd_decode #(.NUM_IRQS(NUM_IRQS)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .cmd_word  (reg_wdata[15:0]),
        .param_we  (param_we),
        .ctrl_we   (ctrl_we),
        .cmd       (cmd),
        .line_sel  (line_sel),
        .rd_req    (rd_req),
        .rd_is_ack (rd_is_ack)
    );

    assign mode_word = mode_from_word(param_q[15:0]);

    for (genvar n = 0; n < NUM_IRQS; n++) begin : g_line
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign irq_o[c*NUM_IRQS+n] = line_irq[n][c];
            assign line_take[n][c]     = take_i[c*NUM_IRQS+n];
        end
        irqd_line #(.NUM_CORES(NUM_CORES)) u_line (
            .clk        (clk),
            .rst        (rst),
            .sel        (line_sel[n]),
            .code       (cmd.code),
            .mode_in    (mode_word),
            .mask_in    (param_q[NUM_CORES-1:0]),
            .en         (en_q),
            .take       (line_take[n]),
            .irq        (line_irq[n]),
            .pend       (line_pend[n]),
            .ack        (line_ack[n]),
            .pulse_mode (pulse_lines[n])
        );
    end

    irqd_status_sel #(
        .NUM_CORES (NUM_CORES),
        .NUM_IRQS  (NUM_IRQS),
        .DATA_W    (DATA_W)
    ) u_status (
        .pend_all (line_pend),
        .ack_all  (line_ack),
        .idx      (cmd.idx[LINE_W-1:0]),
        .want_ack (rd_is_ack),
        .word     (status_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            param_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (param_we)    param_q <= reg_wdata;
            else if (rd_req) param_q <= status_word;
            if (ctrl_we)     en_q <= reg_wdata[0];
        end
    end

    assign reg_rdata = param_q;

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_IRQS  = 16,
    parameter int DATA_W    = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_wr,
    input logic [1:0]                    reg_addr,
    input logic [15:0]                   cmd_word,
    input logic [DATA_W-1:0]             reg_rdata,
    input logic [NUM_CORES*NUM_IRQS-1:0] irq_o,
    input logic                          en_q,
    input logic [NUM_IRQS-1:0]           pulse_lines
);

    logic [NUM_CORES*NUM_IRQS-1:0] pulse_flat;
    logic                          is_cmd, is_raise, is_read, bad_idx;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
        for (genvar n = 0; n < NUM_IRQS; n++) begin : g_n
            assign pulse_flat[c*NUM_IRQS+n] = pulse_lines[n];
        end
    end

    always_comb begin
        is_cmd   = reg_wr && (reg_addr == ADDR_CMD);
        bad_idx  = is_cmd && (32'(cmd_word[15:8]) >= NUM_IRQS);
        is_raise = is_cmd && (cmd_word[7:0] == CMD_RAISE);
        is_read  = is_cmd && !bad_idx &&
                   ((cmd_word[7:0] == CMD_RD_ACK) || (cmd_word[7:0] == CMD_RD_PEND));
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && reg_rdata == '0));

    p_disabled_silent_r10: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> irq_o == '0);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        ((|(irq_o & pulse_flat)) && !is_raise) |=> ((irq_o & pulse_flat) == '0));

    p_status_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        is_read |=> (reg_rdata[DATA_W-1:NUM_CORES] == '0));

    p_bad_index_stable_r12: assert property (@(posedge clk) disable iff (rst)
        bad_idx |=> $stable(reg_rdata));

endmodule

bind irq_distributor irqd_checker #(
    .NUM_CORES (NUM_CORES),
    .NUM_IRQS  (NUM_IRQS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .cmd_word    (reg_wdata[15:0]),
    .reg_rdata   (reg_rdata),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .pulse_lines (pulse_lines)
);

// File: tb/test_irq_distributor.sv
`timescale 1ns/1ps
module test_irq_distributor;

    localparam int NC = 4;
    localparam int NI = 16;
    localparam int FW = NC*NI;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [FW-1:0] take_i = '0;
    logic [FW-1:0] irq_o;

    always #2 clk = ~clk;

    irq_distributor i_irq_distributor (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take_i(take_i), .irq_o(irq_o)
    );

    typedef struct {
        int            cyc;
        logic [FW-1:0] ei;
        logic [31:0]   er;
        string         tag;
    } item_t;

    item_t       sb[$];
    int          cyc_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [31:0]   model_rd = '0;
    logic [FW-1:0] cur_irq = '0;

    initial forever begin
        @(posedge clk);
        cyc_cnt++;
    end

    function automatic logic [FW-1:0] bitv(input int c, input int n);
        return FW'(1) << (c*NI + n);
    endfunction

    // R2 command layout: index in [15:8], code in [7:0]
    function automatic logic [31:0] cmdw(input int idx, input int code);
        return (32'(idx) << 8) | 32'(code);
    endfunction

    task automatic expect_out(input logic [FW-1:0] ei, input logic [31:0] er,
                              input string tag, input int ofs = 0);
        item_t it;
        it.cyc = cyc_cnt + ofs;
        it.ei  = ei;
        it.er  = er;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [FW-1:0] tk = '0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; take_i = tk;
        @(negedge clk);
        reg_wr = 1'b0; take_i = '0;
        if (a == 2'd0) model_rd = d;
    endtask

    task automatic take_only(input logic [FW-1:0] tk);
        @(negedge clk);
        take_i = tk;
        @(negedge clk);
        take_i = '0;
    endtask

    task automatic rdc(input int idx, input int code, input logic [31:0] exp_v, input string tag);
        wr(2'd1, cmdw(idx, code));
        model_rd = exp_v;
        expect_out(cur_irq, exp_v, tag);
    endtask

    // monitor: pops expected items and compares against the ports
    initial forever begin
        @(negedge clk);
        #1;
        while (sb.size() > 0 && sb[0].cyc <= cyc_cnt) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.cyc < cyc_cnt) begin
                n_fail++;
                $display("FAIL %s: sample missed, actual cycle %0d expected cycle %0d",
                         it.tag, cyc_cnt, it.cyc);
            end else if (irq_o !== it.ei || reg_rdata !== it.er) begin
                n_fail++;
                $display("FAIL %s: actual irq=%h rd=%h expected irq=%h rd=%h",
                         it.tag, irq_o, reg_rdata, it.ei, it.er);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out('0, '0, "R1 reset state");
        wr(2'd1, cmdw(2, 3));
        expect_out('0, '0, "R1 disabled after reset");

        wr(2'd2, 32'd1);

        // one-core routing, level trigger
        wr(2'd0, 32'h2);
        wr(2'd1, cmdw(2, 2));
        wr(2'd1, cmdw(2, 3));
        cur_irq = bitv(1, 2);
        expect_out(cur_irq, model_rd, "R2,R3 single core routing");
        rdc(2, 6, 32'h2, "R8 pending after raise");
        rdc(2, 5, 32'h0, "R9 no ack before clear");
        repeat (3) @(negedge clk);
        expect_out(cur_irq, model_rd, "R6 level output holds");
        take_only(bitv(1, 2));
        expect_out(cur_irq, model_rd, "R6 level kept after take");
        rdc(2, 6, 32'h0, "R8 pending cleared by take");
        rdc(2, 5, 32'h0, "R9 take alone does not ack");
        wr(2'd1, cmdw(2, 4));
        cur_irq = '0;
        expect_out(cur_irq, model_rd, "R6 clear lowers output");
        rdc(2, 5, 32'h2, "R9 ack after clear");
        wr(2'd1, cmdw(6, 4));
        rdc(6, 5, 32'h0, "R9 clear without delivery gives no ack");

        // multi-core mask
        wr(2'd0, 32'hB);
        wr(2'd1, cmdw(5, 2));
        wr(2'd1, cmdw(5, 3));
        cur_irq = bitv(0, 5) | bitv(1, 5) | bitv(3, 5);
        expect_out(cur_irq, model_rd, "R4 multi core routing");
        rdc(5, 6, 32'hB, "R8 pending mask multi");
        take_only(bitv(0, 5));
        rdc(5, 6, 32'hA, "R8 pending persists for untaken cores");
        wr(2'd1, cmdw(5, 4));
        cur_irq = '0;
        expect_out(cur_irq, model_rd, "R4 clear multi");
        rdc(5, 5, 32'hB, "R9 ack mask multi");

        // lowest-core destination
        wr(2'd0, 32'h1);
        wr(2'd1, cmdw(7, 1));
        wr(2'd0, 32'hC);
        wr(2'd1, cmdw(7, 2));
        wr(2'd1, cmdw(7, 3));
        cur_irq = bitv(2, 7);
        expect_out(cur_irq, model_rd, "R5 lowest core only");
        rdc(7, 6, 32'h4, "R5 pending only lowest");
        wr(2'd1, cmdw(7, 4));
        cur_irq = '0;
        expect_out(cur_irq, model_rd, "R5 clear");

        // pulse trigger
        wr(2'd0, 32'h100);
        wr(2'd1, cmdw(9, 1));
        wr(2'd0, 32'h5);
        wr(2'd1, cmdw(9, 2));
        wr(2'd1, cmdw(9, 3));
        expect_out(bitv(0, 9) | bitv(2, 9), model_rd, "R7 pulse high");
        expect_out('0, model_rd, "R7 pulse one cycle", 1);
        rdc(9, 6, 32'h5, "R8 sticky pending after pulse");
        take_only(bitv(0, 9) | bitv(2, 9));
        rdc(9, 6, 32'h0, "R8 pending cleared after pulse take");

        // global enable
        wr(2'd0, 32'h1);
        wr(2'd1, cmdw(3, 2));
        wr(2'd2, 32'd0);
        wr(2'd1, cmdw(3, 3));
        expect_out('0, model_rd, "R10 raise ignored while disabled");
        rdc(3, 6, 32'h0, "R10 no pending while disabled");
        wr(2'd2, 32'd1);
        expect_out('0, model_rd, "R10 nothing appears on enable");
        wr(2'd1, cmdw(3, 3));
        cur_irq = bitv(0, 3);
        expect_out(cur_irq, model_rd, "R10 raise when enabled");
        wr(2'd2, 32'd0);
        expect_out('0, model_rd, "R10 outputs gated");
        wr(2'd2, 32'd1);
        expect_out(cur_irq, model_rd, "R10 output restored");
        wr(2'd1, cmdw(3, 4));
        cur_irq = '0;

        // raise and take in the same cycle
        wr(2'd0, 32'h2);
        wr(2'd1, cmdw(4, 2));
        wr(2'd1, cmdw(4, 3), bitv(1, 4));
        cur_irq = bitv(1, 4);
        expect_out(cur_irq, model_rd, "R11 output up on collision");
        rdc(4, 6, 32'h2, "R11 raise wins over take");
        wr(2'd1, cmdw(4, 4));
        cur_irq = '0;
        expect_out(cur_irq, model_rd, "R11 clear");

        // ignored commands
        wr(2'd0, 32'h1234_5678);
        wr(2'd1, cmdw(20, 6));
        expect_out('0, 32'h1234_5678, "R12 read with index out of range");
        wr(2'd1, cmdw(16, 3));
        expect_out('0, 32'h1234_5678, "R12 raise with index out of range");
        wr(2'd0, 32'hF);
        wr(2'd1, cmdw(8, 2));
        wr(2'd1, cmdw(8, 9));
        expect_out('0, 32'hF, "R12 unknown code");
        wr(2'd1, cmdw(8, 3));
        cur_irq = bitv(0, 8) | bitv(1, 8) | bitv(2, 8) | bitv(3, 8);
        expect_out(cur_irq, model_rd, "R4 all cores selected");
        wr(2'd1, cmdw(8, 4));
        cur_irq = '0;
        expect_out(cur_irq, model_rd, "R6 clear all cores");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule